// File: doc/BRIEF.md
# ADC Calibration and Enable Sequencer

This block holds the control bits that take an analog-to-digital converter from power-up through calibration to a usable state. Software writes a one to the calibration request input. The calibration bit then stays high for a fixed number of converter clocks, and hardware clears it. Software then writes the enable bit. After a stabilisation delay the ready flag rises, which tells software that conversions may begin.

The block also reproduces a quirk of the converter's control logic. A short counter starts when calibration ends, and on its fourth count it forces the enable bit back to zero. An enable written during that window is therefore silently lost. The supported recovery is to keep writing enable until ready is seen. Software can also disable the converter through a clear input, which drops ready as well.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset the calibration bit `cal_busy`, the enable bit `en` and the flag `rdy` are all 0.
- R2: A `cal_set` pulse sampled while `cal_busy`=0 and `en`=0 sets `cal_busy` at that edge. `cal_busy` stays 1 for exactly CAL_CYCLES clocks and is then cleared by hardware. A `cal_set` while `cal_busy`=1 has no effect.
- R3: An `en_set` sampled while `cal_busy`=1 is ignored, so `en` stays 0.
- R4: Take the edge at which `cal_busy` falls as edge 0. At edge WIN_CYCLES (default 4), `en` is forced to 0. An `en_set` accepted at edges 1 to WIN_CYCLES-1 is therefore undone. At edge WIN_CYCLES the forced clear wins over `en_set`.
- R5: An `en_set` sampled outside calibration and outside the forced-clear edge sets `en` at that edge, and it stays set.
- R6: `rdy` rises STAB_CYCLES clocks after the edge at which `en` rose. It is only ever 1 while `en` is 1, and it falls at the same edge as `en`.
- R7: `en_clr` clears `en` and `rdy` at the next edge. It wins over a simultaneous `en_set`.
- R8: A `cal_set` sampled while `en`=1 is ignored, so `cal_busy` stays 0.
- R9: When `cal_set` and `en_set` are sampled together from idle, calibration starts and the enable write is ignored.
- R10: If software writes `en_set` on every clock from the end of calibration, `rdy` is reached: `en` is set at edge WIN_CYCLES+1 after the fall and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_set | input | 1 | Write one to the calibration bit |
| en_set | input | 1 | Write one to the enable bit |
| en_clr | input | 1 | Software disable request |
| cal_busy | output | 1 | Calibration bit, cleared by hardware |
| en | output | 1 | Enable bit |
| rdy | output | 1 | Converter ready flag |

## Verification
Two events can fall on the same edge: a software enable write and the internal forced clear that ends the post-calibration window. The bench provokes this by pulsing `en_set` at each edge offset inside the window, including the clearing edge itself. It also writes enable on every clock. A behavioural model that counts edges since the fall of `cal_busy` judges `en` and `rdy` on every clock. It expects the forced clear to win and the first lasting enable to land one edge after the window.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
    localparam int unsigned DEF_CAL_CYCLES  = 8;
    localparam int unsigned DEF_WIN_CYCLES  = 4;
    localparam int unsigned DEF_STAB_CYCLES = 3;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/adc_cal_timer.sv
module adc_cal_timer
    import adc_cal_pkg::*;
#(
    parameter int unsigned CAL_CYCLES = DEF_CAL_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned W = cnt_width(CAL_CYCLES);
    localparam logic [W-1:0] LAST = W'(CAL_CYCLES - 1);

    typedef struct packed {
        logic         busy;
        logic [W-1:0] cnt;
    } cal_state_t;

    cal_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = st_q.busy && (st_q.cnt == LAST);
        if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    assert_cal_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.cnt == '0));
endmodule

// File: rtl/adc_post_cal_window.sv
module adc_post_cal_window
    import adc_cal_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = DEF_WIN_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    localparam int unsigned W = cnt_width(WIN_CYCLES);
    localparam logic [W-1:0] LIMIT = W'(WIN_CYCLES);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = (cnt_q == LIMIT);
        cnt_d = cnt_q;
        if (arm)                 cnt_d = W'(1);
        else if (fire)           cnt_d = '0;
        else if (cnt_q != '0)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_win_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    assert_win_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (cnt_q == W'(1)));
endmodule

// File: rtl/adc_ready_timer.sv
module adc_ready_timer
    import adc_cal_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = DEF_STAB_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_now,
    input  logic en_next,
    output logic rdy
);
    localparam int unsigned W = cnt_width(STAB_CYCLES);
    localparam logic [W-1:0] LAST = W'(STAB_CYCLES - 1);

    typedef struct packed {
        logic         rdy;
        logic [W-1:0] cnt;
    } rdy_state_t;

    rdy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_now || !en_next) begin
            st_d = '0;
        end else if (!st_q.rdy) begin
            if (st_q.cnt == LAST) st_d.rdy = 1'b1;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy = st_q.rdy;

    assert_rdy_after_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy) |-> $past(en_now));
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int unsigned CAL_CYCLES  = DEF_CAL_CYCLES,
    parameter int unsigned WIN_CYCLES  = DEF_WIN_CYCLES,
    parameter int unsigned STAB_CYCLES = DEF_STAB_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_set,
    input  logic en_set,
    input  logic en_clr,
    output logic cal_busy,
    output logic en,
    output logic rdy
);
    logic en_d, en_q;
    logic cal_start, cal_done, force_clr;

    assign cal_start = cal_set && !cal_busy && !en_q;

    adc_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
        .clk(clk), .rst_n(rst_n), .start(cal_start),
        .busy(cal_busy), .done(cal_done)
    );

    adc_post_cal_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk(clk), .rst_n(rst_n), .arm(cal_done), .fire(force_clr)
    );

    always_comb begin
        en_d = en_q;
        if (force_clr)                              en_d = 1'b0;
        else if (en_clr)                            en_d = 1'b0;
        else if (en_set && !cal_busy && !cal_start) en_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    adc_ready_timer #(.STAB_CYCLES(STAB_CYCLES)) u_rdy (
        .clk(clk), .rst_n(rst_n), .en_now(en_q), .en_next(en_d), .rdy(rdy)
    );

    assign en = en_q;

    assert_no_en_in_cal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !en_q);
    assert_force_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> !en_q);
    assert_rdy_implies_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> en_q);
    assert_clr_drops_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (!en_q && !rdy));
    assert_no_cal_when_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !cal_busy) |=> !cal_busy);
endmodule

// File: tb/tb_adc_cal_seq.sv
module tb_adc_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CAL  = 8;
    localparam int WIN  = 4;
    localparam int STAB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_set = 1'b0, en_set = 1'b0, en_clr = 1'b0;
    logic cal_busy, en, rdy;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    adc_cal_seq #(.CAL_CYCLES(CAL), .WIN_CYCLES(WIN), .STAB_CYCLES(STAB)) dut (
        .clk(clk), .rst_n(rst_n), .cal_set(cal_set), .en_set(en_set),
        .en_clr(en_clr), .cal_busy(cal_busy), .en(en), .rdy(rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: remaining calibration cycles, edges since fall
    int cal_left = 0;
    int since_fall = -1;
    int m_en = 0;
    int en_age = 0;
    int m_rdy = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cal_left = 0; since_fall = -1; m_en = 0; en_age = 0; m_rdy = 0;
        end else begin
            bit start, frc;
            int new_en;
            start = cal_set && cal_left == 0 && m_en == 0;
            frc = (since_fall == WIN - 1);
            if (frc) new_en = 0;
            else if (en_clr) new_en = 0;
            else if (en_set && cal_left == 0 && !start) new_en = 1;
            else new_en = m_en;
            if (cal_left == 1) since_fall = 0;
            else if (frc) since_fall = -1;
            else if (since_fall >= 0) since_fall++;
            if (cal_left > 0) cal_left--;
            else if (start) cal_left = CAL;
            if (new_en == 0) en_age = 0;
            else if (m_en == 1) en_age++;
            m_rdy = (new_en == 1 && en_age >= STAB) ? 1 : 0;
            m_en = new_en;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, cal_busy, (cal_left > 0) ? 1 : 0, "cal_busy");
            chk(cur_req, en, m_en, "en");
            chk(cur_req, rdy, m_rdy, "rdy");
        end
    end

    task automatic drive(bit c, bit s, bit x);
        @(negedge clk);
        cal_set = c; en_set = s; en_clr = x;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0);
    endtask

    task automatic run_cal_then_enable_at(int off);
        drive(1, 0, 0);
        idle(CAL - 1);
        // the next edge is the falling edge (edge 0)
        idle(1);
        idle(off - 1);
        drive(0, 1, 0);
        idle(WIN + STAB + 2);
    endtask

    initial begin
        idle(3);
        chk("R1", cal_busy, 0, "reset cal_busy");
        chk("R1", en, 0, "reset en");
        chk("R1", rdy, 0, "reset rdy");
        drive(0, 0, 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R9";
        drive(1, 1, 0);
        drive(0, 0, 0);
        chk("R9", cal_busy, 1, "cal started");
        chk("R9", en, 0, "enable ignored");
        cur_req = "R3";
        drive(0, 1, 0);
        drive(1, 1, 0);
        cur_req = "R2";
        idle(CAL + 1);
        chk("R2", cal_busy, 0, "cleared by hardware");
        cur_req = "R4";
        idle(WIN + 2);

        // enable inside the window at each offset, including the clearing edge
        for (int off = 1; off <= WIN; off++) begin
            cur_req = "R4";
            run_cal_then_enable_at(off);
            chk("R4", en, 0, "enable lost in window");
        end

        cur_req = "R5";
        run_cal_then_enable_at(WIN + 1);
        chk("R5", en, 1, "enable after window");
        cur_req = "R6";
        chk("R6", rdy, 1, "ready after stabilisation");

        cur_req = "R8";
        drive(1, 0, 0);
        drive(0, 0, 0);
        chk("R8", cal_busy, 0, "cal ignored while enabled");

        cur_req = "R7";
        drive(0, 1, 1);
        drive(0, 0, 0);
        chk("R7", en, 0, "clear wins");
        chk("R7", rdy, 0, "ready dropped");

        cur_req = "R10";
        drive(1, 0, 0);
        for (int i = 0; i < CAL + WIN + STAB + 4; i++) drive(0, 1, 0);
        idle(1);
        chk("R10", en, 1, "retry enable");
        chk("R10", rdy, 1, "retry reaches ready");

        cur_req = "R6";
        drive(0, 0, 1);
        idle(2);
        drive(0, 1, 0);
        idle(1);
        chk("R6", rdy, 0, "not ready yet");
        idle(STAB + 1);
        chk("R6", rdy, 1, "ready again");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule